// File: doc/BRIEF.md
# Two-Channel Bus Switch Control Target

This block is the digital core of a two-channel serial-bus switch. It is a small I2C target that holds a one-byte control register. The two lowest register bits drive two channel-enable outputs. The block also gathers two active-low interrupt lines, one per downstream channel, into a single active-low interrupt output. That output is modelled as the enable of an open-drain pull-down.

A bus master addresses the block at a parameterised 7-bit address. It writes one byte to select any mix of channels, including both at once. It reads one byte back to learn which channels are enabled and which channels have a pending interrupt. Interrupt status is taken live from the synchronised interrupt lines at the moment a read byte is loaded. A channel does not need to be enabled for its interrupt to be seen. The bus lines and the interrupt lines each pass through a two-flop synchroniser to the system clock. The data line is only ever pulled low, through an enable output.

Top module: `chsw_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `ch_en` is 2'b00, `sda_pull` is 0, and the register reads back as 0x00 when no interrupt is pending.
- R2: A write to the block's address stores written bit 0 as `ch_en[0]` and written bit 1 as `ch_en[1]`, where 1 enables a channel. All other written bits are ignored, and `ch_en` changes only after an accepted write byte.
- R3: Both channels may be enabled at once (written value 0x03 gives `ch_en` = 2'b11).
- R4: A read returns the following byte:
  - bits 1:0: the current `ch_en`.
  - bit 4: set while `irq_n_in[0]` is low.
  - bit 5: set while `irq_n_in[1]` is low.
  - bits 7:6 and 3:2: always 0.
  - Both interrupt bits are reported independently.
- R5: `irq_pull` is 1 whenever any `irq_n_in` line is low, and 0 when both are high. This does not depend on `ch_en`, and the output follows the inputs after the two-flop synchroniser.
- R6: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a STOP the block releases SDA (`sda_pull` = 0).
- R7: An address byte whose upper 7 bits equal `TGT_ADDR` is acknowledged (SDA pulled low in the ninth clock). The LSB of that byte selects read (1) or write (0). Any other address is not acknowledged, and that transaction leaves `ch_en` unchanged.
- R8: The data byte of an addressed write is acknowledged in its ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain enable) |
| irq_n_in | input | 2 | Active-low interrupt inputs, index = channel |
| ch_en | output | 2 | Channel enables, 1 = channel connected |
| irq_pull | output | 1 | 1 pulls the shared interrupt line low |

## Verification
The bound checker watches the following on every cycle:
- `ch_en` moves only on an accepted write, and then takes the two low bits of the written byte.
- An accepted write byte is acknowledged.
- SDA is let go after every STOP.
- `irq_pull` follows the settled interrupt inputs whatever the channel enables are.

The bench scenarios cover the rest:
- The read-back byte layout with interrupts in every combination.
- Whether a foreign address is refused.
- Whether writes survive a read.
- That a reset in the middle of activity returns the register to zero.

// File: rtl/chsw_pkg.sv
package chsw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_SKIP
  } tgt_state_e;

  // Upper seven bits of a header byte against the own address.
  function automatic logic addr_hit(input logic [7:0] hdr, input logic [6:0] own);
    return hdr[7:1] == own;
  endfunction

  // Byte returned on a read: enables low, pending flags in bits 4/5.
  function automatic logic [7:0] status_byte(input logic [1:0] en, input logic [1:0] irq_n);
    return {2'b00, ~irq_n[1], ~irq_n[0], 2'b00, en};
  endfunction

endpackage

// File: rtl/chsw_sync.sv
module chsw_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[LAST];
endmodule

// File: rtl/chsw_i2c_tgt.sv
module chsw_i2c_tgt
  import chsw_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h70,
  parameter int         BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              start_evt,
  output logic              stop_evt,
  output logic              wr_evt,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              rd_evt
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

  tgt_state_e        state;
  logic              scl_q, sda_q;
  logic              scl_rise, scl_fall;
  logic [CW-1:0]     cnt;
  logic              full;
  logic              is_rd;
  logic [BYTE_W-1:0] sh, tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_evt = scl_s & scl_q &  sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q &  sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      full    <= 1'b0;
      is_rd   <= 1'b0;
      sh      <= '0;
      tx      <= '0;
      sda_oe  <= 1'b0;
      wr_evt  <= 1'b0;
      wr_byte <= '0;
      rd_evt  <= 1'b0;
    end else begin
      wr_evt <= 1'b0;
      rd_evt <= 1'b0;
      if (start_evt) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        full   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        full   <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WDAT: begin
            if (scl_rise && !full) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) full <= 1'b1;
            end else if (scl_fall && full) begin
              full <= 1'b0;
              if (state == ST_ADDR) begin
                if (addr_hit(sh, TGT_ADDR)) begin
                  state  <= ST_AACK;
                  sda_oe <= 1'b1;
                  is_rd  <= sh[0];
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                state   <= ST_WACK;
                sda_oe  <= 1'b1;
                wr_evt  <= 1'b1;
                wr_byte <= sh;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (is_rd) begin
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                rd_evt <= 1'b1;
                state  <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WDAT;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_SKIP;
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                state  <= ST_SKIP;
              end else begin
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/chsw_ctrl.sv
module chsw_ctrl
  import chsw_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h70,
  parameter int         SYNC_STAGES = 2,
  parameter int         N_CH        = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            sda_pull,
  input  logic [N_CH-1:0] irq_n_in,
  output logic [N_CH-1:0] ch_en,
  output logic            irq_pull
);
  localparam int SW = N_CH + 2;

  logic [SW-1:0]   sync_q;
  logic            scl_s, sda_s;
  logic [N_CH-1:0] irq_n_s;
  logic [N_CH-1:0] ctrl_q;
  logic [7:0]      rd_byte;
  logic            start_evt, stop_evt, wr_evt, rd_evt;
  logic [7:0]      wr_byte;

  chsw_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({irq_n_in, scl_in, sda_in}),
    .q     (sync_q)
  );

  assign {irq_n_s, scl_s, sda_s} = sync_q;
  assign rd_byte = status_byte(ctrl_q, irq_n_s);

  chsw_i2c_tgt #(.TGT_ADDR(TGT_ADDR), .BYTE_W(8)) u_tgt (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .rd_byte   (rd_byte),
    .sda_oe    (sda_pull),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .wr_evt    (wr_evt),
    .wr_byte   (wr_byte),
    .rd_evt    (rd_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (wr_evt) ctrl_q <= wr_byte[N_CH-1:0];
  end

  assign ch_en    = ctrl_q;
  assign irq_pull = ~&irq_n_s;
endmodule

// File: rtl/chsw_ctrl_chk.sv
module chsw_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] irq_n_in,
  input logic [1:0] ch_en,
  input logic       irq_pull,
  input logic       sda_pull,
  input logic       wr_evt,
  input logic [7:0] wr_byte,
  input logic       stop_evt
);
  logic [2:0] settle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               settle <= '0;
    else if (settle != 3'd4)  settle <= settle + 1'b1;
  end

  // R2
  chen_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> ch_en == $past(wr_byte[1:0]));

  // R2
  chen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_en) |-> $past(wr_evt));

  // R8
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> sda_pull);

  // R6
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull);

  // R5
  irq_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settle == 3'd4 && !(&$past(irq_n_in)) && !(&$past(irq_n_in, 2)) && !(&$past(irq_n_in, 3)))
      |-> irq_pull);

  // R5
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settle == 3'd4 && (&$past(irq_n_in)) && (&$past(irq_n_in, 2)) && (&$past(irq_n_in, 3)))
      |-> !irq_pull);
endmodule

bind chsw_ctrl chsw_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_n_in (irq_n_in),
  .ch_en    (ch_en),
  .irq_pull (irq_pull),
  .sda_pull (sda_pull),
  .wr_evt   (wr_evt),
  .wr_byte  (wr_byte),
  .stop_evt (stop_evt)
);

// File: tb/chsw_ctrl_bench.sv
module chsw_ctrl_bench;
  localparam logic [6:0] ADDR = 7'h70;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [1:0] irq_n = 2'b11;
  logic       sda_pull, irq_pull;
  logic [1:0] ch_en;
  wire        sda_bus = m_sda & ~sda_pull;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chsw_ctrl #(.TGT_ADDR(ADDR)) u_chsw_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (m_scl),
    .sda_in   (sda_bus),
    .sda_pull (sda_pull),
    .irq_n_in (irq_n),
    .ch_en    (ch_en),
    .irq_pull (irq_pull)
  );

  // {write value, interrupt inputs, expected read byte}
  localparam logic [17:0] VEC [6] = '{
    {8'h01, 2'b11, 8'h01},
    {8'h02, 2'b11, 8'h02},
    {8'h03, 2'b10, 8'h13},
    {8'hFC, 2'b01, 8'h20},
    {8'hFF, 2'b00, 8'h33},
    {8'h00, 2'b00, 8'h30}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(Q);
    seen = sda_bus; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      v[i] = s;
    end
    bus_bit(1'b1, s);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] v, output logic aa, output logic da);
    bus_start();
    put_byte({a, 1'b0}, aa);
    if (aa) put_byte(v, da); else da = 1'b0;
    bus_stop();
    tick(4);
  endtask

  task automatic do_read(output logic aa, output logic [7:0] v);
    bus_start();
    put_byte({ADDR, 1'b1}, aa);
    v = 8'h00;
    if (aa) get_byte(v);
    bus_stop();
    tick(4);
  endtask

  initial begin
    logic aa, da;
    logic [7:0] rv;
    tick(3);
    chk("R1 ch_en in reset", ch_en, 2'b00);
    chk("R1 sda_pull in reset", sda_pull, 1'b0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 ch_en after reset", ch_en, 2'b00);
    do_read(aa, rv);
    chk("R7 read address ack", aa, 1'b1);
    chk("R1 read after reset", rv, 8'h00);

    for (int k = 0; k < 6; k++) begin
      irq_n = VEC[k][9:8];
      do_write(ADDR, VEC[k][17:10], aa, da);
      chk("R7 write address ack", aa, 1'b1);
      chk("R8 data byte ack", da, 1'b1);
      chk("R6 released after stop", sda_pull, 1'b0);
      chk("R2 R3 ch_en after write", ch_en, VEC[k][1:0]);
      chk("R5 irq_pull vs inputs", irq_pull, (VEC[k][9:8] != 2'b11));
      do_read(aa, rv);
      chk("R4 read byte layout", rv, VEC[k][7:0]);
    end

    irq_n = 2'b11;
    do_write(ADDR, 8'h03, aa, da);
    chk("R3 both channels on", ch_en, 2'b11);
    chk("R5 irq_pull idle", irq_pull, 1'b0);
    do_write(ADDR ^ 7'h01, 8'h00, aa, da);
    chk("R7 foreign address nack", aa, 1'b0);
    chk("R7 foreign write no effect", ch_en, 2'b11);
    do_read(aa, rv);
    chk("R2 register kept after read", rv, 8'h03);

    irq_n = 2'b01;
    tick(4);
    chk("R5 irq while channel enabled", irq_pull, 1'b1);
    bus_start();
    put_byte({ADDR, 1'b0}, aa);
    rst_n = 1'b0;
    tick(3);
    chk("R1 reset clears ch_en", ch_en, 2'b00);
    chk("R1 reset releases sda", sda_pull, 1'b0);
    rst_n = 1'b1;
    bus_stop();
    irq_n = 2'b11;
    tick(6);
    do_read(aa, rv);
    chk("R1 read after mid-transfer reset", rv, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule